// File: doc/BRIEF.md
# Chunk-Granular Spare Line Substitution Unit

This unit repairs faulty pieces of a cache data line by steering in pieces of a spare line. Main-array rows are gathered into logical groups. Every group is paired with exactly one spare line. That spare line is cut into equal redundancy units, and each unit is as wide as one data chunk.

A fault map holds one entry per spare line. Inside an entry, each unit has a field made of a valid flag and the index of the row within the group that owns that unit. When a read arrives, the accessed row index is compared against every field of its group's entry. Each chunk of the returned line then comes from the spare line if its field matches, and from the main line otherwise.

The fault map is loaded one field at a time through a synchronous configuration write port. The read path is purely combinational from address and data to the corrected line.

Top module: `spare_sub_unit`

## Requirements
- R1: After reset every fault-map field is invalid, so `fix_line` equals `main_line` and `sub_mask` is all zero for any group and row.
- R2: When the field for unit u of group g is valid and its row equals `rd_row`, a read of group g returns chunk u from `spare_line`. Chunk u occupies bits [u*CHUNK_W +: CHUNK_W], and bit u of `sub_mask` is 1.
- R3: A valid field whose row differs from `rd_row` leaves chunk u equal to the main chunk, with `sub_mask[u]` = 0.
- R4: Writing a field with `cfg_valid` = 0 disables that unit. From then on chunk u comes from main data even when the stored row matches.
- R5: A field written for one group has no effect on reads of any other group.
- R6: Units are independent. Several units of one entry may name different rows, and each chunk follows only its own field.
- R7: A configuration write changes the map on the rising clock edge where `cfg_we` is 1. A read in the same cycle as the write still sees the old field.
- R8: Whenever `sub_mask` is zero, `fix_line` equals `main_line`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fault-map write port |
| rst_n | input | 1 | Asynchronous active-low reset; clears all valid flags |
| rd_group | input | GRP_W | Logical group of the accessed row |
| rd_row | input | ROW_W | Index of the accessed row within its group |
| main_line | input | LINE_W | Data line read from the main array |
| spare_line | input | LINE_W | Spare line belonging to the accessed group |
| cfg_we | input | 1 | Fault-map field write enable |
| cfg_group | input | GRP_W | Entry (group) being written |
| cfg_unit | input | UNIT_W | Redundancy unit field being written |
| cfg_valid | input | 1 | Valid flag value to store |
| cfg_row | input | ROW_W | Owning row index to store |
| fix_line | output | LINE_W | Corrected data line |
| sub_mask | output | UNITS | One bit per chunk, set when the spare unit is selected |

## Verification
The two functions that can meet in one cycle are a configuration write and a combinational read that hit the same group, row and unit. The bench sets up both in one low clock phase. Before the edge it checks that the chunk still carries main data. Just after the edge, with the write removed, it checks that the same read now returns spare data. The per-chunk result is judged against a fault-map model kept in the bench, which is updated only after each write edge.

// File: rtl/spare_sub_unit.sv
module spare_sub_unit #(
  parameter int LINE_W       = 64,
  parameter int CHUNK_W      = 8,
  parameter int ROWS_PER_GRP = 4,
  parameter int NUM_GRPS     = 4,
  localparam int UNITS  = LINE_W / CHUNK_W,
  localparam int ROW_W  = (ROWS_PER_GRP > 1) ? $clog2(ROWS_PER_GRP) : 1,
  localparam int GRP_W  = (NUM_GRPS > 1) ? $clog2(NUM_GRPS) : 1,
  localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [GRP_W-1:0]  rd_group,
  input  logic [ROW_W-1:0]  rd_row,
  input  logic [LINE_W-1:0] main_line,
  input  logic [LINE_W-1:0] spare_line,
  input  logic              cfg_we,
  input  logic [GRP_W-1:0]  cfg_group,
  input  logic [UNIT_W-1:0] cfg_unit,
  input  logic              cfg_valid,
  input  logic [ROW_W-1:0]  cfg_row,
  output logic [LINE_W-1:0] fix_line,
  output logic [UNITS-1:0]  sub_mask
);

  logic [NUM_GRPS-1:0][UNITS-1:0]            map_vld;
  logic [NUM_GRPS-1:0][UNITS-1:0][ROW_W-1:0] map_row;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_vld <= '0;
      map_row <= '0;
    end else if (cfg_we) begin
      map_vld[cfg_group][cfg_unit] <= cfg_valid;
      map_row[cfg_group][cfg_unit] <= cfg_row;
    end
  end

  for (genvar u = 0; u < UNITS; u++) begin : g_chunk
    assign sub_mask[u] = map_vld[rd_group][u] && (map_row[rd_group][u] == rd_row);
    assign fix_line[u*CHUNK_W +: CHUNK_W] = sub_mask[u] ? spare_line[u*CHUNK_W +: CHUNK_W]
                                                        : main_line[u*CHUNK_W +: CHUNK_W];
  end

endmodule

// File: rtl/spare_sub_unit_chk.sv
module spare_sub_unit_chk #(
  parameter int LINE_W       = 64,
  parameter int CHUNK_W      = 8,
  parameter int ROWS_PER_GRP = 4,
  parameter int NUM_GRPS     = 4,
  localparam int UNITS  = LINE_W / CHUNK_W,
  localparam int ROW_W  = (ROWS_PER_GRP > 1) ? $clog2(ROWS_PER_GRP) : 1,
  localparam int GRP_W  = (NUM_GRPS > 1) ? $clog2(NUM_GRPS) : 1,
  localparam int UNIT_W = (UNITS > 1) ? $clog2(UNITS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GRP_W-1:0]  rd_group,
  input logic [ROW_W-1:0]  rd_row,
  input logic [LINE_W-1:0] main_line,
  input logic [LINE_W-1:0] spare_line,
  input logic              cfg_we,
  input logic [GRP_W-1:0]  cfg_group,
  input logic [UNIT_W-1:0] cfg_unit,
  input logic              cfg_valid,
  input logic [ROW_W-1:0]  cfg_row,
  input logic [LINE_W-1:0] fix_line,
  input logic [UNITS-1:0]  sub_mask
);

  // R1
  reset_clears_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> sub_mask == '0);

  // R7
  write_takes_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_valid) |=>
      ((rd_group == $past(cfg_group) && rd_row == $past(cfg_row)) -> sub_mask[$past(cfg_unit)]));

  // R4
  invalid_unit_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_valid) |=>
      ((rd_group == $past(cfg_group)) -> !sub_mask[$past(cfg_unit)]));

  // R8
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_mask == '0) |-> fix_line == main_line);

  // R2
  spare_chunk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sub_mask[0] |-> fix_line[CHUNK_W-1:0] == spare_line[CHUNK_W-1:0]);

endmodule

bind spare_sub_unit spare_sub_unit_chk #(
  .LINE_W(LINE_W), .CHUNK_W(CHUNK_W), .ROWS_PER_GRP(ROWS_PER_GRP), .NUM_GRPS(NUM_GRPS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_group(rd_group), .rd_row(rd_row),
  .main_line(main_line), .spare_line(spare_line), .cfg_we(cfg_we),
  .cfg_group(cfg_group), .cfg_unit(cfg_unit), .cfg_valid(cfg_valid),
  .cfg_row(cfg_row), .fix_line(fix_line), .sub_mask(sub_mask)
);

// File: tb/spare_sub_unit_tb.sv
module spare_sub_unit_tb;
  localparam int LINE_W = 64, CHUNK_W = 8, ROWS = 4, GRPS = 4;
  localparam int UNITS = LINE_W / CHUNK_W;

  logic clk = 0, rst_n = 0;
  logic [1:0] rd_group = 0, rd_row = 0, cfg_group = 0, cfg_row = 0;
  logic [2:0] cfg_unit = 0;
  logic cfg_we = 0, cfg_valid = 0;
  logic [LINE_W-1:0] main_line = 64'h5756555453525150;
  logic [LINE_W-1:0] spare_line = 64'hC7C6C5C4C3C2C1C0;
  logic [LINE_W-1:0] fix_line;
  logic [UNITS-1:0] sub_mask;

  bit m_vld [GRPS][UNITS];
  int m_row [GRPS][UNITS];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spare_sub_unit u_dut (
    .clk(clk), .rst_n(rst_n), .rd_group(rd_group), .rd_row(rd_row),
    .main_line(main_line), .spare_line(spare_line), .cfg_we(cfg_we),
    .cfg_group(cfg_group), .cfg_unit(cfg_unit), .cfg_valid(cfg_valid),
    .cfg_row(cfg_row), .fix_line(fix_line), .sub_mask(sub_mask));

  task automatic check(string req, logic [LINE_W-1:0] act, logic [LINE_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_check(string req, int g, int r);
    logic [LINE_W-1:0] exp_line;
    logic [UNITS-1:0] exp_mask;
    rd_group = 2'(g); rd_row = 2'(r);
    #2;
    for (int u = 0; u < UNITS; u++) begin
      exp_mask[u] = m_vld[g][u] && m_row[g][u] == r;
      exp_line[u*CHUNK_W +: CHUNK_W] = exp_mask[u] ? spare_line[u*CHUNK_W +: CHUNK_W]
                                                   : main_line[u*CHUNK_W +: CHUNK_W];
    end
    check(req, fix_line, exp_line);
    check(req, LINE_W'(sub_mask), LINE_W'(exp_mask));
  endtask

  task automatic write_field(int g, int u, bit v, int r);
    @(negedge clk);
    cfg_we = 1; cfg_group = 2'(g); cfg_unit = 3'(u); cfg_valid = v; cfg_row = 2'(r);
    @(posedge clk); #1;
    cfg_we = 0;
    m_vld[g][u] = v; m_row[g][u] = r;
  endtask

  task automatic t_reset;
    for (int g = 0; g < GRPS; g++)
      for (int r = 0; r < ROWS; r++) read_check("R1 reset", g, r);
  endtask

  task automatic t_match;
    write_field(0, 3, 1, 2);
    read_check("R2 match", 0, 2);
    read_check("R3 mismatch", 0, 1);
    read_check("R8 pass", 0, 0);
  endtask

  task automatic t_invalidate;
    write_field(0, 3, 0, 2);
    read_check("R4 invalid", 0, 2);
  endtask

  task automatic t_groups;
    write_field(2, 7, 1, 3);
    for (int g = 0; g < GRPS; g++) read_check("R5 groups", g, 3);
  endtask

  task automatic t_multi;
    write_field(1, 0, 1, 0);
    write_field(1, 5, 1, 1);
    write_field(1, 6, 1, 0);
    write_field(1, 7, 1, 3);
    for (int r = 0; r < ROWS; r++) read_check("R6 multi", 1, r);
    main_line = 64'h0F1E2D3C4B5A6978; spare_line = 64'h8796A5B4C3D2E1F0;
    for (int r = 0; r < ROWS; r++) read_check("R6 data", 1, r);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    rd_group = 2'd3; rd_row = 2'd1;
    cfg_we = 1; cfg_group = 2'd3; cfg_unit = 3'd2; cfg_valid = 1; cfg_row = 2'd1;
    #2;
    check("R7 before edge", LINE_W'(sub_mask[2]), '0);
    @(posedge clk); #1;
    cfg_we = 0;
    m_vld[3][2] = 1; m_row[3][2] = 1;
    read_check("R7 after edge", 3, 1);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int g = 0; g < GRPS; g++)
      for (int u = 0; u < UNITS; u++) begin m_vld[g][u] = 0; m_row[g][u] = 0; end
    #35;
    t_reset;
    @(negedge clk); rst_n = 1;
    t_reset;
    t_match;
    t_invalidate;
    t_groups;
    t_multi;
    t_same_cycle;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule